// File: doc/BRIEF.md
# Conditional skip and link unit

This block decides the outcome of a conditional-skip micro-instruction. An instruction word whose top nibble is C names a data register, a mask register and a test. The external register file is read through the two select outputs, and the block compares one byte of the data register against the low byte of the mask register. Some tests need no mask at all. It then computes the address of the instruction plus four.

When the test succeeds, that address is written to register 0, which is the instruction address register. The following instruction is therefore skipped. When the test fails, the same address is written to register 1, the link register, and execution continues at the instruction plus two. The instruction that falls through can then branch to a subroutine, and that subroutine returns by moving the link value into register 0.

The result is registered and appears one cycle after the request. A request whose opcode is not C completes with no register write. The data and mask registers are only read, never written.

Top module: `skiplink_unit`

## Requirements
- R1: `sel_data` is instruction bits [11:8] and `sel_mask` is bits [7:4], combinationally; the opcode is bits [15:12] and the test code is bits [3:0].
- R2: `done` is high in the cycle after each cycle with `valid_in` high, and low in the cycle after each cycle with `valid_in` low.
- R3: Test codes 0, 1 and 2 succeed when the data low byte is unsigned less than or equal to, strictly less than, or equal to the mask low byte.
- R4: Test code 3 succeeds when the data low byte is 00 and test code 4 when it is FF; the mask value has no effect on either.
- R5: Test code 5 succeeds when every 1 bit of the mask byte is 1 in the data low byte; test code 6 succeeds when every such bit is 0 in the data low byte; mask 0 bits are don't-care.
- R6: Test code 7 applies the test of code 5 to the data high byte; the data low byte has no effect.
- R7: Test codes 8 to F give the inverse result of the code minus 8.
- R8: On success `wr_ia_en` is high, `wr_link_en` is low, and both `wr_data` and `next_addr` equal the instruction address plus 4, modulo 2^16.
- R9: On failure `wr_link_en` is high, `wr_ia_en` is low, `wr_data` is the address plus 4 and `next_addr` the address plus 2, whatever the data register number, including 1.
- R10: An opcode other than C gives `done` with both write enables low, `cond_met` low and `next_addr` equal to the address plus 2.
- R11: While `rst_n` is low, `done`, `cond_met` and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Request strobe for the instruction on `instr` |
| instr | input | 16 | Micro-instruction word |
| cur_addr | input | 16 | Address of the instruction |
| data_val | input | 16 | Value of the register picked by `sel_data` |
| mask_val | input | 16 | Value of the register picked by `sel_mask` |
| sel_data | output | 4 | Data register number for the register file |
| sel_mask | output | 4 | Mask register number for the register file |
| done | output | 1 | Result valid, one cycle after the request |
| cond_met | output | 1 | Test outcome after any inversion |
| wr_ia_en | output | 1 | Write `wr_data` to register 0 |
| wr_link_en | output | 1 | Write `wr_data` to register 1 |
| wr_data | output | 16 | Instruction address plus 4 |
| next_addr | output | 16 | Address the sequencer fetches next |

## Verification
A wrong test decode or the wrong byte lane shows up as a reversed `cond_met` and as the wrong write enable. This happens in the same single cycle after the request, so every test code is driven with operands on both sides of its boundary. A wrong increment shows as a wrong `wr_data` or `next_addr`, and the address wrap at FFFE and FFFC catches a width error. The result register holds no state beyond one request, so a stuck or leaked value can only appear as a `done` pulse or a write enable with no request one cycle earlier. The bench checks this directly.

// File: rtl/skiplink_pkg.sv
package skiplink_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0] OPC_SKIP = 4'hC;

  typedef enum logic [2:0] {
    T_LE     = 3'd0,
    T_LT     = 3'd1,
    T_EQ     = 3'd2,
    T_ZERO   = 3'd3,
    T_ONES   = 3'd4,
    T_ALLSET = 3'd5,
    T_ALLCLR = 3'd6,
    T_HISET  = 3'd7
  } test_e;

  typedef struct packed {
    logic [3:0] opc;
    logic [3:0] ra;
    logic [3:0] rb;
    logic       invert;
    test_e      test;
  } skip_word_t;

  // Raw outcome of one test on an already selected data byte.
  function automatic logic byte_test(test_e t, logic [BYTE_W-1:0] d,
                                     logic [BYTE_W-1:0] m);
    logic r;
    case (t)
      T_LE:     r = (d <= m);
      T_LT:     r = (d < m);
      T_EQ:     r = (d == m);
      T_ZERO:   r = (d == '0);
      T_ONES:   r = (d == '1);
      T_ALLSET,
      T_HISET:  r = ((~d & m) == '0);
      T_ALLCLR: r = ((d & m) == '0);
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] step_addr(logic [WORD_W-1:0] a,
                                                  int unsigned n);
    return a + WORD_W'(n);
  endfunction
endpackage

// File: rtl/skiplink_decode.sv
module skiplink_decode
  import skiplink_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output skip_word_t        fields,
  output logic              is_skip
);
  always_comb begin
    fields  = skip_word_t'(instr);
    is_skip = (fields.opc == OPC_SKIP);
  end
endmodule

// File: rtl/skiplink_cond.sv
module skiplink_cond
  import skiplink_pkg::*;
(
  input  skip_word_t        fields,
  input  logic [WORD_W-1:0] data_val,
  input  logic [WORD_W-1:0] mask_val,
  output logic              raw_hit,
  output logic              hit
);
  logic [BYTE_W-1:0] lane;

  always_comb begin
    lane    = (fields.test == T_HISET) ? data_val[WORD_W-1 -: BYTE_W]
                                       : data_val[BYTE_W-1:0];
    raw_hit = byte_test(fields.test, lane, mask_val[BYTE_W-1:0]);
    hit     = raw_hit ^ fields.invert;
  end
endmodule

// File: rtl/skiplink_target.sv
module skiplink_target
  import skiplink_pkg::*;
#(
  parameter int unsigned INSTR_BYTES = 2
) (
  input  logic [WORD_W-1:0] addr,
  output logic [WORD_W-1:0] skip_addr,
  output logic [WORD_W-1:0] fall_addr
);
  localparam int unsigned SKIP_BYTES = 2 * INSTR_BYTES;

  always_comb begin
    skip_addr = step_addr(addr, SKIP_BYTES);
    fall_addr = step_addr(addr, INSTR_BYTES);
  end
endmodule

// File: rtl/skiplink_unit.sv
module skiplink_unit
  import skiplink_pkg::*;
#(
  parameter int unsigned INSTR_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] cur_addr,
  input  logic [WORD_W-1:0] data_val,
  input  logic [WORD_W-1:0] mask_val,
  output logic [3:0]        sel_data,
  output logic [3:0]        sel_mask,
  output logic              done,
  output logic              cond_met,
  output logic              wr_ia_en,
  output logic              wr_link_en,
  output logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] next_addr
);
  localparam int unsigned SKIP_BYTES = 2 * INSTR_BYTES;

  skip_word_t        fields;
  logic              is_skip;
  logic              raw_hit;
  logic              hit;
  logic [WORD_W-1:0] skip_addr;
  logic [WORD_W-1:0] fall_addr;
  logic              take_now;
  logic              link_now;

  skiplink_decode u_dec (
    .instr   (instr),
    .fields  (fields),
    .is_skip (is_skip)
  );

  skiplink_cond u_cond (
    .fields   (fields),
    .data_val (data_val),
    .mask_val (mask_val),
    .raw_hit  (raw_hit),
    .hit      (hit)
  );

  skiplink_target #(.INSTR_BYTES(INSTR_BYTES)) u_tgt (
    .addr      (cur_addr),
    .skip_addr (skip_addr),
    .fall_addr (fall_addr)
  );

  assign sel_data = fields.ra;
  assign sel_mask = fields.rb;
  assign take_now = is_skip && hit;
  assign link_now = is_skip && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      cond_met   <= 1'b0;
      wr_ia_en   <= 1'b0;
      wr_link_en <= 1'b0;
      wr_data    <= '0;
      next_addr  <= '0;
    end else begin
      done       <= valid_in;
      cond_met   <= valid_in && take_now;
      wr_ia_en   <= valid_in && take_now;
      wr_link_en <= valid_in && link_now;
      if (valid_in) begin
        wr_data   <= skip_addr;
        next_addr <= take_now ? skip_addr : fall_addr;
      end
    end
  end

  assert_done_follows_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !done);
  assert_single_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ia_en, wr_link_en}));
  assert_write_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ia_en || wr_link_en) |-> done);
  assert_target_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && is_skip) |=> (wr_data == $past(cur_addr) + WORD_W'(SKIP_BYTES)));
  assert_taken_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && is_skip && hit) |=> (wr_ia_en && next_addr == wr_data));
  assert_link_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && is_skip && !hit) |=> (wr_link_en && !wr_ia_en &&
      next_addr == $past(cur_addr) + WORD_W'(INSTR_BYTES)));
  assert_invert_flips_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && is_skip && fields.invert) |=> (cond_met == !$past(raw_hit)));
  assert_other_opcode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !is_skip) |=> (!wr_ia_en && !wr_link_en && !cond_met));
endmodule

// File: tb/skiplink_unit_test.sv
module skiplink_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] cur_addr = '0;
  logic [15:0] data_val = '0;
  logic [15:0] mask_val = '0;
  logic [3:0]  sel_data, sel_mask;
  logic        done, cond_met, wr_ia_en, wr_link_en;
  logic [15:0] wr_data, next_addr;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skiplink_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .instr(instr),
    .cur_addr(cur_addr), .data_val(data_val), .mask_val(mask_val),
    .sel_data(sel_data), .sel_mask(sel_mask), .done(done),
    .cond_met(cond_met), .wr_ia_en(wr_ia_en), .wr_link_en(wr_link_en),
    .wr_data(wr_data), .next_addr(next_addr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected outcome, written from the requirement text.
  function automatic logic expect_hit(logic [3:0] code, logic [15:0] d, logic [15:0] m);
    logic [7:0] lo, hi, mk;
    logic r;
    lo = d[7:0]; hi = d[15:8]; mk = m[7:0];
    case (code[2:0])
      3'd0: r = !(lo > mk);
      3'd1: r = (mk > lo);
      3'd2: r = (lo ^ mk) == 8'h00;
      3'd3: r = (lo | 8'h00) == 8'h00;
      3'd4: r = &lo;
      3'd5: r = (lo | ~mk) == 8'hFF;
      3'd6: r = (~lo | ~mk) == 8'hFF;
      default: r = (hi | ~mk) == 8'hFF;
    endcase
    return code[3] ? !r : r;
  endfunction

  // Issue one request and check every result in the following cycle.
  task automatic issue(string tag, logic [3:0] opc, logic [3:0] ra, logic [3:0] rb,
                       logic [3:0] code, logic [15:0] d, logic [15:0] m,
                       logic [15:0] a);
    logic hit;
    logic jmp;
    @(negedge clk);
    instr = {opc, ra, rb, code};
    data_val = d; mask_val = m; cur_addr = a; valid_in = 1'b1;
    #1;
    check({tag, " R1 sel_data"}, 32'(sel_data), 32'(ra));
    check({tag, " R1 sel_mask"}, 32'(sel_mask), 32'(rb));
    jmp = (opc == 4'hC);
    hit = jmp && expect_hit(code, d, m);
    @(negedge clk);
    valid_in = 1'b0;
    check({tag, " R2 done"}, 32'(done), 32'd1);
    check({tag, " cond_met"}, 32'(cond_met), 32'(hit));
    check({tag, " R8 wr_ia_en"}, 32'(wr_ia_en), 32'(hit));
    check({tag, " R9 wr_link_en"}, 32'(wr_link_en), 32'(jmp && !hit));
    if (jmp) check({tag, " R8 wr_data"}, 32'(wr_data), 32'(16'(a + 16'd4)));
    check({tag, " R9 next_addr"}, 32'(next_addr),
          32'(hit ? 16'(a + 16'd4) : 16'(a + 16'd2)));
  endtask

  task automatic test_reset();
    check("R11 done in reset", 32'(done), 32'd0);
    check("R11 cond_met in reset", 32'(cond_met), 32'd0);
    check("R11 enables in reset", 32'({wr_ia_en, wr_link_en}), 32'd0);
  endtask

  task automatic test_compare();
    issue("R3 le equal", 4'hC, 4'h2, 4'h3, 4'h0, 16'h0040, 16'h0040, 16'h0100);
    issue("R3 le above", 4'hC, 4'h2, 4'h3, 4'h0, 16'h0041, 16'h0040, 16'h0100);
    issue("R3 lt equal", 4'hC, 4'h2, 4'h3, 4'h1, 16'h0040, 16'h0040, 16'h0110);
    issue("R3 lt below", 4'hC, 4'h2, 4'h3, 4'h1, 16'h007F, 16'h0080, 16'h0110);
    issue("R3 lt unsigned", 4'hC, 4'h2, 4'h3, 4'h1, 16'h0080, 16'h007F, 16'h0110);
    issue("R3 eq hit", 4'hC, 4'h4, 4'h5, 4'h2, 16'h12A5, 16'h34A5, 16'h0120);
    issue("R3 eq miss", 4'hC, 4'h4, 4'h5, 4'h2, 16'h00A5, 16'h00A4, 16'h0120);
  endtask

  task automatic test_forced();
    issue("R4 zero hit", 4'hC, 4'h6, 4'h7, 4'h3, 16'hFF00, 16'h0055, 16'h0200);
    issue("R4 zero miss", 4'hC, 4'h6, 4'h7, 4'h3, 16'h0001, 16'h0000, 16'h0200);
    issue("R4 ones hit", 4'hC, 4'h6, 4'h7, 4'h4, 16'h00FF, 16'h0000, 16'h0202);
    issue("R4 ones miss", 4'hC, 4'h6, 4'h7, 4'h4, 16'hFFFE, 16'h00FE, 16'h0202);
  endtask

  task automatic test_mask();
    issue("R5 allset hit", 4'hC, 4'h8, 4'h9, 4'h5, 16'h00BD, 16'h00AC, 16'h0300);
    issue("R5 allset miss", 4'hC, 4'h8, 4'h9, 4'h5, 16'h00A8, 16'h00AC, 16'h0300);
    issue("R5 allclr hit", 4'hC, 4'h8, 4'h9, 4'h6, 16'h0053, 16'h00AC, 16'h0302);
    issue("R5 allclr miss", 4'hC, 4'h8, 4'h9, 4'h6, 16'h0057, 16'h00AC, 16'h0302);
  endtask

  task automatic test_high();
    issue("R6 hi hit", 4'hC, 4'hA, 4'hB, 4'h7, 16'hF000, 16'h00C0, 16'h0400);
    issue("R6 hi miss", 4'hC, 4'hA, 4'hB, 4'h7, 16'h40FF, 16'h00C0, 16'h0400);
  endtask

  task automatic test_invert();
    issue("R7 gt via 8", 4'hC, 4'h2, 4'h3, 4'h8, 16'h0041, 16'h0040, 16'h0500);
    issue("R7 ne via A", 4'hC, 4'h2, 4'h3, 4'hA, 16'h0040, 16'h0040, 16'h0500);
    issue("R7 nonzero via B", 4'hC, 4'h2, 4'h3, 4'hB, 16'h0010, 16'h0000, 16'h0502);
    issue("R7 hi via F", 4'hC, 4'h2, 4'h3, 4'hF, 16'h4000, 16'h00C0, 16'h0502);
  endtask

  task automatic test_wrap();
    issue("R8 wrap taken", 4'hC, 4'h2, 4'h3, 4'h2, 16'h0011, 16'h0011, 16'hFFFE);
    issue("R9 wrap link", 4'hC, 4'h2, 4'h3, 4'h2, 16'h0011, 16'h0012, 16'hFFFC);
  endtask

  task automatic test_link_r1();
    issue("R9 data reg 1", 4'hC, 4'h1, 4'h4, 4'h4, 16'h0000, 16'h0000, 16'h0600);
    issue("R9 data reg 0", 4'hC, 4'h0, 4'h1, 4'h0, 16'h00FF, 16'h0010, 16'h0602);
  endtask

  task automatic test_other_opcode();
    issue("R10 opcode 2", 4'h2, 4'h3, 4'h4, 4'h2, 16'h0011, 16'h0011, 16'h0700);
    issue("R10 opcode D", 4'hD, 4'h3, 4'h4, 4'h3, 16'h0000, 16'h0000, 16'h0710);
  endtask

  task automatic test_idle();
    @(negedge clk);
    check("R2 done low when idle", 32'(done), 32'd0);
    check("R2 no write when idle", 32'({wr_ia_en, wr_link_en}), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_idle();
    test_compare();
    test_idle();
    test_forced();
    test_mask();
    test_high();
    test_invert();
    test_wrap();
    test_link_r1();
    test_other_opcode();
    test_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule